// File: doc/BRIEF.md
# Board Power Sequencer and Processor Reset Generator

The block brings up four board supply rails in a fixed order and holds a processor in reset until all of them are stable. A high user enable starts the ramp. Each rail's enable is raised only after the rail before it has reported good and a settle interval has elapsed. A rail that does not report good in time, or that drops after bring-up, sends the block to a fault state. In that state every rail is switched off, and the block stays there until the user enable is taken low and raised again. A force-on input keeps the two core rails powered whatever the user enable does.

The processor reset is active low. It is released only when the user enable, the master reset input, every power-good input and an internal completion flag are all high. The completion flag sets after all rails have been continuously good for a fixed delay. A boot-selection strap is captured once, after a cold reset of the block, and the master reset input never recaptures it. A filtered copy of the user enable is also provided for status indicators.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Rails are enabled strictly in the order 1.0 V, 1.8 V, 1.5 V, 3.3 V. Each enable rises only after the previous rail's power-good has been seen, and in normal operation an enable never rises while an earlier one is low.
- R2: The next enable rises exactly SETTLE_CYC clock cycles after the previous rail's power-good input goes high.
- R3: If the awaited power-good does not arrive within PG_TIMEOUT cycles, all four enables drop. They stay low while the user enable remains high, and a new ramp starts only after the user enable goes low and then high again.
- R4: While force_on is high, en_1v0 and en_1v8 are high regardless of the user enable. en_1v5 and en_3v3 are unaffected by force_on.
- R5: cpu_rst_n is low whenever any of the following is low: user_en, mrst_n, any of the four power-good inputs, or the completion flag.
- R6: The completion flag, and with it cpu_rst_n, rises exactly DONE_DLY cycles after pwr_good rises, when user_en and mrst_n are high.
- R7: pwr_good is high only when the sequence has completed and all four power-good inputs are high.
- R8: boot_sel captures boot_strap once, on the first clock after rst_n is released. Its value is 1 for SPI flash boot and 0 for SD-card boot. A pulse on mrst_n does not recapture it.
- R9: user_en_dly rises exactly EN_DLY cycles after user_en goes high and stays high. A high pulse shorter than EN_DLY cycles never raises it. It falls one clock after user_en falls.
- R10: When user_en goes low during a ramp or after completion, all non-forced rail enables drop on the next clock.
- R11: If any power-good input falls after completion, all rail enables drop and the block waits for a user enable toggle, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold (power-on) reset of the block, active low |
| user_en | input | 1 | User enable, active high |
| mrst_n | input | 1 | Master reset input, active low |
| force_on | input | 1 | Holds the 1.0 V and 1.8 V enables high |
| pg_1v0 | input | 1 | 1.0 V converter power good |
| pg_1v8 | input | 1 | 1.8 V converter power good |
| pg_1v5 | input | 1 | 1.5 V converter power good |
| pg_3v3 | input | 1 | 3.3 V supply good |
| boot_strap | input | 1 | Boot selection strap |
| en_1v0 | output | 1 | 1.0 V converter enable |
| en_1v8 | output | 1 | 1.8 V converter enable |
| en_1v5 | output | 1 | 1.5 V converter enable |
| en_3v3 | output | 1 | 3.3 V switch enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| pwr_good | output | 1 | All supplies good |
| boot_sel | output | 1 | Latched boot selection (1 SPI flash, 0 SD card) |
| user_en_dly | output | 1 | Filtered, delayed user enable |

## Verification
A converter model drives each power-good input one clock after the matching enable, and it can hold any chosen rail low. A clean ramp measures the exact gaps between each power-good and the next enable, and between pwr_good and reset release, which tells a correct settle or completion count from one that is off by a cycle. A rail that never reports good is used to separate the timeout path from normal settling. A rail lost after completion confirms that the fault is latched until the user enable is toggled. Separate patterns on the user enable, master reset, force-on and strap show which conditions gate only the reset and which also switch the rails.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int SETTLE_CYC = 4,
  parameter int PG_TIMEOUT = 16,
  parameter int DONE_DLY   = 8,
  parameter int EN_DLY     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic user_en,
  input  logic mrst_n,
  input  logic force_on,
  input  logic pg_1v0,
  input  logic pg_1v8,
  input  logic pg_1v5,
  input  logic pg_3v3,
  input  logic boot_strap,
  output logic en_1v0,
  output logic en_1v8,
  output logic en_1v5,
  output logic en_3v3,
  output logic cpu_rst_n,
  output logic pwr_good,
  output logic boot_sel,
  output logic user_en_dly
);
  localparam int TW = $clog2(SETTLE_CYC + PG_TIMEOUT + 1);
  localparam int DW = $clog2(DONE_DLY + 1);
  localparam int EW = $clog2(EN_DLY + 1);
  localparam logic [TW-1:0] SETTLE_LAST  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] TIMEOUT_LAST = TW'(PG_TIMEOUT - 1);
  localparam logic [DW-1:0] DONE_LAST    = DW'(DONE_DLY - 1);
  localparam logic [EW-1:0] EN_FULL      = EW'(EN_DLY);

  typedef enum logic [2:0] {S_OFF, S_RAMP, S_SETTLE, S_ON, S_FAULT} st_t;

  st_t           st;
  logic [1:0]    step;
  logic [TW-1:0] tmr;
  logic [DW-1:0] done_cnt;
  logic          done;
  logic [EW-1:0] en_cnt;
  logic          strap_taken;
  logic [3:0]    rail_on;

  wire [3:0] pg_vec = {pg_3v3, pg_1v5, pg_1v8, pg_1v0};
  wire       pg_all = &pg_vec;
  wire       pg_cur = pg_vec[step];
  wire       active = (st == S_RAMP) || (st == S_SETTLE) || (st == S_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      step <= '0;
      tmr  <= '0;
    end else if (!user_en) begin
      st   <= S_OFF;
      step <= '0;
      tmr  <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st   <= S_RAMP;
          step <= '0;
          tmr  <= '0;
        end
        S_RAMP: begin
          if (pg_cur) begin
            st  <= S_SETTLE;
            tmr <= '0;
          end else if (tmr == TIMEOUT_LAST) begin
            st <= S_FAULT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SETTLE: begin
          if (!pg_cur) begin
            st <= S_FAULT;
          end else if (tmr == SETTLE_LAST) begin
            tmr <= '0;
            if (step == 2'd3) st <= S_ON;
            else begin
              st   <= S_RAMP;
              step <= step + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_ON:    if (!pg_all) st <= S_FAULT;
        default: st <= S_FAULT;
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_rail
    assign rail_on[i] = active && (step >= 2'(i));
  end

  assign en_1v0 = rail_on[0] | force_on;
  assign en_1v8 = rail_on[1] | force_on;
  assign en_1v5 = rail_on[2];
  assign en_3v3 = rail_on[3];
  assign pwr_good = (st == S_ON) && pg_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_cnt <= '0;
      done     <= 1'b0;
    end else if (!pwr_good) begin
      done_cnt <= '0;
      done     <= 1'b0;
    end else if (!done) begin
      if (done_cnt == DONE_LAST) done <= 1'b1;
      else done_cnt <= done_cnt + 1'b1;
    end
  end

  assign cpu_rst_n = user_en & mrst_n & pg_all & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_cnt <= '0;
    else if (!user_en) en_cnt <= '0;
    else if (en_cnt != EN_FULL) en_cnt <= en_cnt + 1'b1;
  end

  assign user_en_dly = (en_cnt == EN_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_taken <= 1'b0;
      boot_sel    <= 1'b0;
    end else if (!strap_taken) begin
      strap_taken <= 1'b1;
      boot_sel    <= boot_strap;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic user_en,
  input logic mrst_n,
  input logic force_on,
  input logic pg_1v0,
  input logic pg_1v8,
  input logic pg_1v5,
  input logic pg_3v3,
  input logic en_1v0,
  input logic en_1v8,
  input logic en_1v5,
  input logic en_3v3,
  input logic cpu_rst_n,
  input logic pwr_good,
  input logic boot_sel,
  input logic user_en_dly
);
  logic arm1, arm2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm1 <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      arm1 <= 1'b1;
      arm2 <= arm1;
    end
  end

  wire all_pg = pg_1v0 & pg_1v8 & pg_1v5 & pg_3v3;

  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_3v3 |-> en_1v5) and (en_1v5 |-> en_1v8) and (en_1v8 |-> en_1v0));

  assert_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |-> (en_1v0 && en_1v8));

  assert_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_en || !mrst_n || !all_pg) |-> !cpu_rst_n);

  assert_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> all_pg);

  assert_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm2 |-> $stable(boot_sel));

  assert_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !user_en |=> !user_en_dly);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !user_en |=> (!en_1v5 && !en_3v3));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (.*);

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
  localparam int SETTLE = 4, TMO = 16, DDLY = 8, EDLY = 5;

  logic clk = 1'b0, rst_n = 1'b0, user_en = 1'b0, mrst_n = 1'b1, force_on = 1'b0, boot_strap = 1'b0;
  logic [3:0] pg_q = 4'b0, fail = 4'b0;
  logic en_1v0, en_1v8, en_1v5, en_3v3, cpu_rst_n, pwr_good, boot_sel, user_en_dly;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.SETTLE_CYC(SETTLE), .PG_TIMEOUT(TMO), .DONE_DLY(DDLY), .EN_DLY(EDLY)) u0 (
    .clk(clk), .rst_n(rst_n), .user_en(user_en), .mrst_n(mrst_n), .force_on(force_on),
    .pg_1v0(pg_q[0]), .pg_1v8(pg_q[1]), .pg_1v5(pg_q[2]), .pg_3v3(pg_q[3]),
    .boot_strap(boot_strap), .en_1v0(en_1v0), .en_1v8(en_1v8), .en_1v5(en_1v5),
    .en_3v3(en_3v3), .cpu_rst_n(cpu_rst_n), .pwr_good(pwr_good), .boot_sel(boot_sel),
    .user_en_dly(user_en_dly));

  // converter model: good follows enable one cycle later unless held in failure
  always @(negedge clk) pg_q <= {en_3v3, en_1v5, en_1v8, en_1v0} & ~fail;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ens();
    return {en_3v3, en_1v5, en_1v8, en_1v0};
  endfunction

  task automatic cold_reset(input logic strap);
    boot_strap = strap;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bring_up();
    user_en = 1'b1;
    for (int i = 0; i < 300 && !cpu_rst_n; i++) @(negedge clk);
  endtask

  task automatic toggle_off();
    user_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    cold_reset(1'b0);
    check(ens() == 0, "R1 rails off after reset", ens(), 0);
    check(!cpu_rst_n && !pwr_good, "R5 reset held after reset", cpu_rst_n, 0);
    check(!user_en_dly, "R9 filtered enable low after reset", user_en_dly, 0);
  endtask

  task automatic t_ramp();
    int t_en[4], t_pg[4], cyc, t_good, t_rel;
    bit order_ok;
    for (int i = 0; i < 4; i++) begin t_en[i] = -1; t_pg[i] = -1; end
    t_good = -1; t_rel = -1; cyc = 0; order_ok = 1;
    user_en = 1'b1;
    for (int k = 0; k < 300 && t_rel < 0; k++) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 4; i++) begin
        if (ens()[i] && t_en[i] < 0) t_en[i] = cyc;
        if (pg_q[i] && t_pg[i] < 0) t_pg[i] = cyc;
      end
      if (en_1v8 && !en_1v0) order_ok = 0;
      if (en_1v5 && !en_1v8) order_ok = 0;
      if (en_3v3 && !en_1v5) order_ok = 0;
      if (pwr_good && t_good < 0) t_good = cyc;
      if (cpu_rst_n && t_rel < 0) t_rel = cyc;
    end
    check(order_ok, "R1 no enable ahead of an earlier one", 0, 1);
    for (int i = 1; i < 4; i++) begin
      check(t_pg[i-1] > 0 && t_en[i] > t_pg[i-1], "R1 enable after previous good", t_en[i], t_pg[i-1] + 1);
      check(t_en[i] - t_pg[i-1] == SETTLE, "R2 settle gap", t_en[i] - t_pg[i-1], SETTLE);
    end
    check(t_good > 0 && pwr_good, "R7 power good after full ramp", pwr_good, 1);
    check(t_rel - t_good == DDLY, "R6 completion delay", t_rel - t_good, DDLY);
  endtask

  task automatic t_filter();
    int n;
    toggle_off();
    user_en = 1'b1;
    repeat (EDLY - 1) @(negedge clk);
    check(!user_en_dly, "R9 short pulse not passed", user_en_dly, 0);
    user_en = 1'b0;
    repeat (2) @(negedge clk);
    check(!user_en_dly, "R9 short pulse not passed", user_en_dly, 0);
    user_en = 1'b1;
    n = 0;
    for (int k = 0; k < 50 && !user_en_dly; k++) begin @(negedge clk); n++; end
    check(n == EDLY, "R9 filter delay", n, EDLY);
    user_en = 1'b0;
    @(negedge clk);
    check(!user_en_dly, "R9 falls one clock after enable", user_en_dly, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_master_reset();
    bring_up();
    mrst_n = 1'b0;
    #1;
    check(!cpu_rst_n, "R5 master reset asserts reset", cpu_rst_n, 0);
    repeat (4) @(negedge clk);
    check(ens() == 15 && pwr_good, "R5 rails unaffected by master reset", ens(), 15);
    mrst_n = 1'b1;
    @(negedge clk);
    check(cpu_rst_n, "R5 reset released after master reset", cpu_rst_n, 1);
  endtask

  task automatic t_user_drop();
    user_en = 1'b0;
    #1;
    check(!cpu_rst_n, "R5 reset on user enable low", cpu_rst_n, 0);
    @(negedge clk);
    check(ens() == 0, "R10 rails drop after user enable low", ens(), 0);
  endtask

  task automatic t_timeout();
    fail = 4'b0100;
    user_en = 1'b1;
    repeat (100) @(negedge clk);
    check(ens() == 0, "R3 rails dropped on timeout", ens(), 0);
    check(!pwr_good && !cpu_rst_n, "R3 no power good on timeout", pwr_good, 0);
    fail = 4'b0;
    repeat (40) @(negedge clk);
    check(ens() == 0, "R3 stays off until toggle", ens(), 0);
    toggle_off();
    bring_up();
    check(cpu_rst_n && ens() == 15, "R3 ramp after toggle", ens(), 15);
  endtask

  task automatic t_rail_loss();
    fail = 4'b0100;
    repeat (4) @(negedge clk);
    check(ens() == 0, "R11 rails drop on lost good", ens(), 0);
    check(!cpu_rst_n && !pwr_good, "R11 reset on lost good", cpu_rst_n, 0);
    fail = 4'b0;
    repeat (30) @(negedge clk);
    check(ens() == 0, "R11 waits for toggle", ens(), 0);
    toggle_off();
  endtask

  task automatic t_force();
    force_on = 1'b1;
    repeat (3) @(negedge clk);
    check(ens() == 3, "R4 forced rails only", ens(), 3);
    check(!cpu_rst_n && !pwr_good, "R4 force does not release reset", cpu_rst_n, 0);
    bring_up();
    check(ens() == 15 && cpu_rst_n, "R4 ramp with force on", ens(), 15);
    user_en = 1'b0;
    repeat (2) @(negedge clk);
    check(ens() == 3, "R4 forced rails kept after user enable low", ens(), 3);
    force_on = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_boot();
    cold_reset(1'b0);
    check(boot_sel == 1'b0, "R8 SD boot captured", boot_sel, 0);
    boot_strap = 1'b1;
    mrst_n = 1'b0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(boot_sel == 1'b0, "R8 no recapture on master reset", boot_sel, 0);
    cold_reset(1'b1);
    check(boot_sel == 1'b1, "R8 SPI boot captured on cold reset", boot_sel, 1);
    boot_strap = 1'b0;
    repeat (3) @(negedge clk);
    check(boot_sel == 1'b1, "R8 strap change after capture ignored", boot_sel, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ramp();
    t_filter();
    t_master_reset();
    t_user_drop();
    t_timeout();
    t_rail_loss();
    t_force();
    t_boot();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule